// File: doc/BRIEF.md
# SIMD Lane Permutation Unit

This block rearranges the elements of two vector operands, A and B, in a single pass. Five operations are available. Byte extract takes a window from the pair. Reverse flips the order of elements inside fixed containers. Transpose, interleave and de-interleave each produce two results. The element size is chosen at run time from 8, 16 or 32 bits; the reverse container is chosen from 16, 32 or 64 bits. A narrow mode works on the low 64 bits of each operand only.

One operation is presented per clock with `in_valid`. Both results and an error flag are registered and appear one clock later with `out_valid`. Operations that write two results return the new A on `res_a` and the new B on `res_b`. Extract and reverse write only `res_a`, and `res_b` returns operand B. If the operation, size or index is not allowed, the unit raises `cfg_err` and returns both operands unchanged.

Encodings:
- `op`: 0 = extract, 1 = reverse, 2 = transpose, 3 = interleave, 4 = de-interleave; 5 to 7 are illegal.
- `esz`: 0, 1, 2, 3 mean 8, 16, 32, 64 bits.
- `csz`: 0, 1, 2, 3 mean 8, 16, 32, 64 bits.
- `wide`: 1 = 128-bit mode, 0 = 64-bit mode.

Element x of an operand is bits `[x*E +: E]`, where E is the element width. "Lanes" below means the live width: 128 bits in wide mode, 64 bits in narrow mode.

Top module: `lane_permute`

## Requirements
- R1: Extract (op 0) sets byte x of `res_a` to byte x+`imm` of the byte concatenation {B,A}, with A supplying the low bytes. `esz` is ignored, and `res_b` returns B.
- R2: Extract accepts `imm` from 0 to 15 in wide mode and from 0 to 7 in narrow mode. An index of 8 to 15 in narrow mode is illegal (see R8).
- R3: Interleave (op 3) forms the element sequence P = A[0],B[0],A[1],B[1],…. The first half of P goes to `res_a` and the second half to `res_b`. For example, with 32-bit elements, A = {D,C,B,A} and B = {H,G,F,E} (written high to low) give `res_a` = {F,B,E,A} and `res_b` = {H,D,G,C}.
- R4: De-interleave (op 4) takes the element sequence A then B. It returns the even-numbered elements in `res_a` and the odd-numbered elements in `res_b`. Applied to an interleave result, it restores the original operands.
- R5: Transpose (op 2) exchanges A[2x+1] with B[2x] for every pair x. All other elements keep their place.
- R6: Reverse (op 1) puts B into `res_a` with the element order reversed inside each container of width `csz`. `res_b` returns B.
- R7: In narrow mode only bits 63:0 of A and B are used, and bits 127:64 of both results are zero for every legal operation.
- R8: The following are illegal: `op` 5 to 7; any transpose, interleave or de-interleave with `esz`=3; any reverse with `esz`=3 or `csz`≤`esz`; and the case in R2. An illegal operation sets `cfg_err`=1, with `res_a`=A and `res_b`=B over the full 128 bits. A legal operation sets `cfg_err`=0.
- R9: `out_valid` is `in_valid` delayed by exactly one clock. The results and `cfg_err` hold their values while `in_valid` is low. Synchronous reset clears `out_valid`, `cfg_err` and both results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 3 | Operation code |
| esz | input | 2 | Element size code |
| csz | input | 2 | Reverse container size code |
| wide | input | 1 | 1 = 128-bit mode, 0 = 64-bit mode |
| imm | input | 4 | Extract byte index |
| opnd_a | input | 128 | Operand A (low half of pairs) |
| opnd_b | input | 128 | Operand B (high half of pairs) |
| out_valid | output | 1 | Result valid, one clock after in_valid |
| res_a | output | 128 | First result |
| res_b | output | 128 | Second result |
| cfg_err | output | 1 | Illegal operation flag |

## Verification
The bench first runs the stated 32-bit interleave example. It then feeds that result back through de-interleave and expects the original operands, so a design that mixes up which half feeds the even slots fails both checks. It sweeps every legal operation, size, container and mode with pseudo-random operands. This exposes a byte-route formula that is wrong for one element size, or upper lanes that leak through in narrow mode. The error cases aim at the legality rules: a narrow extract index of 8, a reverse whose container equals its element, opcode 6, and 64-bit interleave. A design that decodes any of these as legal returns shuffled data instead of the untouched operands. Idle cycles with changing inputs show whether the outputs are held.

// File: rtl/lp_pkg.sv
package lp_pkg;

  typedef enum logic [2:0] {
    OP_EXT = 3'd0,
    OP_REV = 3'd1,
    OP_TRN = 3'd2,
    OP_ZIP = 3'd3,
    OP_UZP = 3'd4
  } lp_op_e;

  // Source byte index in the pool {B bytes, A bytes} for output byte p
  // (p < nbq selects res_a, otherwise res_b); -1 means drive zero.
  function automatic int lp_src_byte(input int p, input int op, input int esz,
                                     input int csz, input int wide, input int imm,
                                     input int nbq);
    int nb, j, eb, ne, e, t, k, cb, c, o, per, ni, x, se;
    nb = (wide != 0) ? nbq : nbq / 2;
    if (p < nbq) begin
      if (p >= nb) return -1;
      j = p;
    end else begin
      if (p - nbq >= nb) return -1;
      j = p - nbq + nb;
    end
    eb = 1 << esz;
    ne = nb / eb;
    e  = j / eb;
    t  = j % eb;
    k  = j;
    case (op)
      0: k = (j < nb) ? j + imm : j;
      1: begin
        if (j < nb) begin
          cb  = 1 << csz;
          c   = j - (j % cb);
          o   = j % cb;
          per = cb / eb;
          ni  = per - 1 - (o / eb);
          k   = nb + c + ni * eb + t;
        end
      end
      2: begin
        if (e < ne) begin
          if ((e % 2) == 1) k = (ne + e - 1) * eb + t;
        end else begin
          x = e - ne;
          if ((x % 2) == 0) k = (x + 1) * eb + t;
        end
      end
      3: begin
        se = ((e % 2) == 0) ? e / 2 : ne + e / 2;
        k  = se * eb + t;
      end
      4: begin
        se = (e < ne) ? 2 * e : 2 * (e - ne) + 1;
        k  = se * eb + t;
      end
      default: k = j;
    endcase
    if (k < 0 || k >= 2 * nb) return -1;
    return (k < nb) ? k : nbq + k - nb;
  endfunction

endpackage

// File: rtl/lp_legal.sv
module lp_legal #(
  parameter int VEC_W = 128,
  localparam int NBQ   = VEC_W / 8,
  localparam int IMM_W = $clog2(NBQ)
) (
  input  logic [2:0]       op,
  input  logic [1:0]       esz,
  input  logic [1:0]       csz,
  input  logic             wide,
  input  logic [IMM_W-1:0] imm,
  output logic             err
);
  import lp_pkg::*;

  logic [IMM_W-1:0] imm_max;

  always_comb begin
    imm_max = wide ? IMM_W'(NBQ - 1) : IMM_W'(NBQ / 2 - 1);
    case (op)
      OP_EXT:                 err = (imm > imm_max);
      OP_REV:                 err = (esz == 2'd3) || (csz <= esz);
      OP_TRN, OP_ZIP, OP_UZP: err = (esz == 2'd3);
      default:                err = 1'b1;
    endcase
  end
endmodule

// File: rtl/lp_route.sv
module lp_route #(
  parameter int VEC_W = 128,
  localparam int NBQ   = VEC_W / 8,
  localparam int POOL  = 2 * NBQ,
  localparam int PW    = $clog2(POOL),
  localparam int IMM_W = $clog2(NBQ)
) (
  input  logic [2:0]       op,
  input  logic [1:0]       esz,
  input  logic [1:0]       csz,
  input  logic             wide,
  input  logic [IMM_W-1:0] imm,
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  output logic [VEC_W-1:0] ra,
  output logic [VEC_W-1:0] rb
);
  import lp_pkg::*;

  logic [7:0] pool [POOL];
  logic [7:0] outb [POOL];

  genvar gi;
  generate
    for (gi = 0; gi < NBQ; gi++) begin : g_pool
      assign pool[gi]       = a[gi*8 +: 8];
      assign pool[gi + NBQ] = b[gi*8 +: 8];
    end

    for (gi = 0; gi < POOL; gi++) begin : g_byte
      int          src;
      logic [PW-1:0] sel;
      always_comb begin
        src = lp_src_byte(gi, int'(op), int'(esz), int'(csz), int'(wide),
                          int'(imm), NBQ);
        sel = src[PW-1:0];
        outb[gi] = (src < 0) ? 8'h00 : pool[sel];
      end
    end

    for (gi = 0; gi < NBQ; gi++) begin : g_out
      assign ra[gi*8 +: 8] = outb[gi];
      assign rb[gi*8 +: 8] = outb[gi + NBQ];
    end
  endgenerate
endmodule

// File: rtl/lp_out_reg.sv
module lp_out_reg #(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             err_c,
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  input  logic [VEC_W-1:0] ra_c,
  input  logic [VEC_W-1:0] rb_c,
  output logic             out_valid,
  output logic             cfg_err,
  output logic [VEC_W-1:0] res_a,
  output logic [VEC_W-1:0] res_b
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      cfg_err   <= 1'b0;
      res_a     <= '0;
      res_b     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        cfg_err <= err_c;
        res_a   <= err_c ? a : ra_c;
        res_b   <= err_c ? b : rb_c;
      end
    end
  end
endmodule

// File: rtl/lane_permute.sv
module lane_permute #(
  parameter int VEC_W = 128,
  localparam int IMM_W = $clog2(VEC_W / 8)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [2:0]       op,
  input  logic [1:0]       esz,
  input  logic [1:0]       csz,
  input  logic             wide,
  input  logic [IMM_W-1:0] imm,
  input  logic [VEC_W-1:0] opnd_a,
  input  logic [VEC_W-1:0] opnd_b,
  output logic             out_valid,
  output logic [VEC_W-1:0] res_a,
  output logic [VEC_W-1:0] res_b,
  output logic             cfg_err
);
  logic             err_c;
  logic [VEC_W-1:0] ra_c, rb_c;

  lp_legal #(.VEC_W(VEC_W)) u_legal (
    .op(op), .esz(esz), .csz(csz), .wide(wide), .imm(imm), .err(err_c)
  );

  lp_route #(.VEC_W(VEC_W)) u_route (
    .op(op), .esz(esz), .csz(csz), .wide(wide), .imm(imm),
    .a(opnd_a), .b(opnd_b), .ra(ra_c), .rb(rb_c)
  );

  lp_out_reg #(.VEC_W(VEC_W)) u_reg (
    .clk(clk), .rst(rst), .in_valid(in_valid), .err_c(err_c),
    .a(opnd_a), .b(opnd_b), .ra_c(ra_c), .rb_c(rb_c),
    .out_valid(out_valid), .cfg_err(cfg_err), .res_a(res_a), .res_b(res_b)
  );
endmodule

// File: rtl/lane_permute_sva.sv
module lane_permute_sva #(
  parameter int VEC_W = 128,
  localparam int IMM_W = $clog2(VEC_W / 8)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [2:0]       op,
  input logic [1:0]       esz,
  input logic [1:0]       csz,
  input logic             wide,
  input logic [IMM_W-1:0] imm,
  input logic [VEC_W-1:0] opnd_a,
  input logic [VEC_W-1:0] opnd_b,
  input logic             out_valid,
  input logic [VEC_W-1:0] res_a,
  input logic [VEC_W-1:0] res_b,
  input logic             cfg_err
);
  localparam int H = VEC_W / 2;

  a_r9_valid_rise: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r9_valid_fall: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(res_a) && $stable(res_b) && $stable(cfg_err)));

  a_r8_err_passthrough: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cfg_err) |-> (res_a == $past(opnd_a) && res_b == $past(opnd_b)));

  a_r8_wide_elem_illegal: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op >= 3'd2 && op <= 3'd4 && esz == 2'd3) |=> cfg_err);

  a_r1_ext_zero_identity: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd0 && wide && imm == '0)
      |=> (!cfg_err && res_a == $past(opnd_a) && res_b == $past(opnd_b)));

  a_r6_rev_keeps_b: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd1 && wide) |=> (cfg_err || res_b == $past(opnd_b)));

  a_r7_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wide) |=> (cfg_err || (res_a[VEC_W-1:H] == '0 && res_b[VEC_W-1:H] == '0)));
endmodule

bind lane_permute lane_permute_sva #(.VEC_W(VEC_W)) u_sva (.*);

// File: tb/lane_permute_tb.sv
module lane_permute_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst, in_valid, wide, out_valid, cfg_err;
  logic [2:0]   op;
  logic [1:0]   esz, csz;
  logic [3:0]   imm;
  logic [127:0] opnd_a, opnd_b, res_a, res_b;

  lane_permute u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .esz(esz), .csz(csz),
    .wide(wide), .imm(imm), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .out_valid(out_valid), .res_a(res_a), .res_b(res_b), .cfg_err(cfg_err)
  );

  typedef struct {
    logic [127:0] ea;
    logic [127:0] eb;
    logic         ee;
    string        tag;
  } exp_t;

  exp_t         q[$];
  int           checks = 0, errors = 0;
  bit           have_last = 0;
  logic [127:0] last_a, last_b;
  logic         last_e;
  logic [31:0]  lfsr = 32'h1ACE_2B7D;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic logic [31:0] get_el(input logic [127:0] v, input int idx, input int ebits);
    logic [127:0] s;
    s = v >> (idx * ebits);
    return (ebits == 32) ? s[31:0] : (s[31:0] & ((32'h1 << ebits) - 1));
  endfunction

  function automatic logic [127:0] put_el(input logic [127:0] v, input int idx, input int ebits,
                                          input logic [31:0] val);
    return v | (128'(val) << (idx * ebits));
  endfunction

  function automatic void model(input int mop, input int mesz, input int mcsz, input bit mw,
                                input int mimm, input logic [127:0] a, input logic [127:0] b,
                                output logic [127:0] ra, output logic [127:0] rb,
                                output logic er);
    int nb, ebits, ne, per, src, k;
    logic [31:0]  cat [32];
    logic [127:0] msk;
    nb = mw ? 16 : 8;
    er = (mop > 4) || (mop == 0 && mimm > nb - 1) ||
         (mop == 1 && (mesz > 2 || mcsz <= mesz)) || (mop >= 2 && mop <= 4 && mesz > 2);
    if (er) begin
      ra = a; rb = b; return;
    end
    msk   = mw ? {128{1'b1}} : {64'h0, {64{1'b1}}};
    ebits = 8 << mesz;
    ne    = nb * 8 / ebits;
    ra = '0; rb = '0;
    case (mop)
      0: begin
        for (int x = 0; x < nb; x++) begin
          k  = x + mimm;
          ra = put_el(ra, x, 8, (k < nb) ? get_el(a, k, 8) : get_el(b, k - nb, 8));
        end
        rb = b & msk;
      end
      1: begin
        per = (8 << mcsz) / ebits;
        for (int x = 0; x < ne; x++) begin
          src = (x / per) * per + per - 1 - (x % per);
          ra  = put_el(ra, x, ebits, get_el(b, src, ebits));
        end
        rb = b & msk;
      end
      2: begin
        for (int x = 0; x < ne; x += 2) begin
          ra = put_el(ra, x,     ebits, get_el(a, x, ebits));
          ra = put_el(ra, x + 1, ebits, get_el(b, x, ebits));
          rb = put_el(rb, x,     ebits, get_el(a, x + 1, ebits));
          rb = put_el(rb, x + 1, ebits, get_el(b, x + 1, ebits));
        end
      end
      3: begin
        for (int x = 0; x < ne; x++) begin
          cat[2*x]   = get_el(a, x, ebits);
          cat[2*x+1] = get_el(b, x, ebits);
        end
        for (int x = 0; x < ne; x++) begin
          ra = put_el(ra, x, ebits, cat[x]);
          rb = put_el(rb, x, ebits, cat[ne + x]);
        end
      end
      default: begin
        for (int x = 0; x < ne; x++) begin
          cat[x]      = get_el(a, x, ebits);
          cat[ne + x] = get_el(b, x, ebits);
        end
        for (int x = 0; x < ne; x++) begin
          ra = put_el(ra, x, ebits, cat[2*x]);
          rb = put_el(rb, x, ebits, cat[2*x+1]);
        end
      end
    endcase
  endfunction

  task automatic send_exp(input int mop, input int mesz, input int mcsz, input bit mw,
                          input int mimm, input logic [127:0] a, input logic [127:0] b,
                          input logic [127:0] xa, input logic [127:0] xb, input logic xe,
                          input string tag);
    exp_t it;
    @(negedge clk);
    it.ea = xa; it.eb = xb; it.ee = xe; it.tag = tag;
    q.push_back(it);
    op = 3'(mop); esz = 2'(mesz); csz = 2'(mcsz); wide = mw; imm = 4'(mimm);
    opnd_a = a; opnd_b = b; in_valid = 1'b1;
  endtask

  task automatic send(input int mop, input int mesz, input int mcsz, input bit mw,
                      input int mimm, input logic [127:0] a, input logic [127:0] b,
                      input string tag);
    logic [127:0] xa, xb;
    logic         xe;
    model(mop, mesz, mcsz, mw, mimm, a, b, xa, xb, xe);
    send_exp(mop, mesz, mcsz, mw, mimm, a, b, xa, xb, xe, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      opnd_a = ~opnd_a; opnd_b = {opnd_b[0], opnd_b[127:1]};
      op = op + 3'd1; imm = imm + 4'd3;
    end
  endtask

  function automatic logic [127:0] rnd128();
    logic [127:0] v;
    for (int i = 0; i < 4; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = lfsr * 32'h0019_660D + 32'h3C6E_F35F;
      v[i*32 +: 32] = lfsr;
    end
    return v;
  endfunction

  // Scoreboard monitor: samples 2 ns after each rising edge.
  always begin
    logic v;
    exp_t it;
    @(posedge clk);
    v = in_valid && !rst;
    #2;
    if (!rst) begin
      chk("R9 out_valid timing", {127'h0, out_valid}, {127'h0, v});
      if (out_valid) begin
        if (q.size() == 0) begin
          chk("R9 unexpected result", 128'h1, 128'h0);
        end else begin
          it = q.pop_front();
          chk({it.tag, " res_a"}, res_a, it.ea);
          chk({it.tag, " res_b"}, res_b, it.eb);
          chk({it.tag, " cfg_err"}, {127'h0, cfg_err}, {127'h0, it.ee});
          last_a = it.ea; last_b = it.eb; last_e = it.ee; have_last = 1;
        end
      end else if (have_last) begin
        chk("R9 hold res_a", res_a, last_a);
        chk("R9 hold res_b", res_b, last_b);
        chk("R9 hold cfg_err", {127'h0, cfg_err}, {127'h0, last_e});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired actual=hung expected=done");
    report();
  end

  initial begin
    logic [127:0] wa, wb, za, zb, ra0, rb0, ba, bb;
    logic         e0;
    rst = 1'b1; in_valid = 1'b0; op = '0; esz = '0; csz = '0; wide = 1'b1; imm = '0;
    opnd_a = '0; opnd_b = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset out_valid", {127'h0, out_valid}, 128'h0);
    chk("R9 reset cfg_err", {127'h0, cfg_err}, 128'h0);
    chk("R9 reset res_a", res_a, 128'h0);

    for (int i = 0; i < 16; i++) begin
      ba[i*8 +: 8] = 8'(i);
      bb[i*8 +: 8] = 8'(8'h10 + i);
    end

    // R3 stated example, then R4 restores it
    wa = {32'hDDDD_DDDD, 32'hCCCC_CCCC, 32'hBBBB_BBBB, 32'hAAAA_AAAA};
    wb = {32'h7777_7777, 32'h6666_6666, 32'hFFFF_FFFF, 32'hEEEE_EEEE};
    za = {32'hFFFF_FFFF, 32'hBBBB_BBBB, 32'hEEEE_EEEE, 32'hAAAA_AAAA};
    zb = {32'h7777_7777, 32'hDDDD_DDDD, 32'h6666_6666, 32'hCCCC_CCCC};
    send_exp(3, 2, 0, 1, 0, wa, wb, za, zb, 1'b0, "R3 zip32 example");
    send_exp(4, 2, 0, 1, 0, za, zb, wa, wb, 1'b0, "R4 unzip restores");
    idle(2);

    // R1 / R2 extract
    send(0, 0, 0, 1, 0,  ba, bb, "R1 ext imm0");
    send(0, 0, 0, 1, 5,  ba, bb, "R1 ext imm5");
    send(0, 2, 0, 1, 15, ba, bb, "R1 ext imm15 esz ignored");
    send(0, 0, 0, 0, 7,  ba, bb, "R2 narrow ext imm7");
    send(0, 0, 0, 0, 8,  ba, bb, "R2 narrow ext imm8 illegal");
    idle(1);

    // R5 / R6 / R3 / R4 fixed patterns
    send(2, 0, 0, 1, 0, ba, bb, "R5 trn8");
    send(2, 1, 0, 1, 0, ba, bb, "R5 trn16");
    send(1, 0, 3, 1, 0, ba, bb, "R6 rev8 in 64");
    send(1, 1, 2, 1, 0, ba, bb, "R6 rev16 in 32");
    send(3, 0, 0, 1, 0, ba, bb, "R3 zip8");
    send(4, 1, 0, 1, 0, ba, bb, "R4 uzp16");
    send(3, 1, 0, 0, 0, ba, bb, "R7 narrow zip16");
    send(1, 0, 3, 0, 0, ba, bb, "R7 narrow rev8");
    idle(3);

    // R8 illegal combinations
    send(1, 1, 1, 1, 0, ba, bb, "R8 rev container equals element");
    send(6, 0, 0, 1, 0, ba, bb, "R8 opcode 6");
    send(3, 3, 0, 1, 0, ba, bb, "R8 zip esz 64");
    send(1, 0, 0, 1, 0, ba, bb, "R8 rev csz 8");
    send(2, 3, 0, 0, 0, ba, bb, "R8 narrow trn esz 64");
    idle(2);

    // Sweep of all legal shapes with pseudo-random operands
    for (int w = 0; w < 2; w++)
      for (int o = 0; o < 5; o++)
        for (int s = 0; s < 3; s++)
          for (int c = s + 1; c < 4; c++) begin
            if (o != 1 && c != s + 1) continue;
            wa = rnd128(); wb = rnd128();
            send(o, s, c, w[0], (o == 0) ? int'(wa[3:0]) % (w[0] ? 16 : 8) : 0,
                 wa, wb, (o == 0) ? "R1 sweep" : (o == 1) ? "R6 sweep" :
                 (o == 2) ? "R5 sweep" : (o == 3) ? "R3 sweep" : "R4 sweep");
          end

    // R4 round trip on random data, 8-bit lanes, narrow mode
    wa = rnd128(); wb = rnd128();
    model(3, 0, 0, 1'b0, 0, wa, wb, ra0, rb0, e0);
    send(3, 0, 0, 0, 0, wa, wb, "R4 narrow zip8");
    send_exp(4, 0, 0, 0, 0, ra0, rb0, {64'h0, wa[63:0]}, {64'h0, wb[63:0]}, 1'b0,
             "R4 narrow unzip8 restores");
    idle(4);

    if (q.size() != 0) chk("R9 results outstanding", 128'(q.size()), 128'h0);
    report();
  end
endmodule